// File: doc/BRIEF.md
# Sequenced Majority-Gate Full Adder

This block adds three single bits using nothing but a three-input majority gate whose operands can each be inverted as an operation is issued, plus a small bank of buffer flip-flops that hold intermediate and final results. There is no XOR anywhere. A small sequencer runs a fixed three-operation schedule. Each operation evaluates the majority gate on a chosen set of sources and copies the result into one buffer.

A one-clock start strobe in the idle state latches the three operand bits. The block then works through three compute steps and a done step, one clock each. The carry ends up in the first buffer and the sum in the third. The buffers model storage that survives idle periods: neither reset nor the end of a sequence clears them. Only a copy operation or the dedicated clear input changes them. A neighbouring unit can therefore read them at any time through the buffer read port.

Top module: `maj_full_adder`

## Requirements
- R1: While `rst` is high on a rising edge, the sequencer returns to idle, so `busy` and `done` are low in the following cycle.
- R2: `start` is acted on only in the idle state (`busy` low). A start seen while busy does not restart or lengthen the sequence and does not replace the operands.
- R3: Suppose `start` is sampled on rising edge k. Then `busy` is high from edge k to edge k+4, and `done` is high for exactly one cycle, from edge k+3 to edge k+4.
- R4: Buffer index 0 (FF1) receives Maj(A, B, Cin), and `cout` always reflects FF1.
- R5: Buffer index 1 (FF2) receives Maj(A, B, NOT Cin).
- R6: Buffer index 2 (FF3) receives Maj(NOT FF1, FF2, Cin), and `sum` always reflects FF3. When `done` is high, {`cout`,`sum`} equals A+B+Cin as a 2-bit number.
- R7: A, B and Cin are captured on the start edge. Changes to them during the sequence do not affect the results.
- R8: The buffers keep their contents through idle cycles and through `rst`. They change only when a compute step copies into them.
- R9: While `clr` is high on a rising edge, every buffer bit becomes 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high sequencer reset |
| clr | input | 1 | Synchronous buffer clear |
| start | input | 1 | Begin a sequence (honoured only when idle) |
| a_in | input | 1 | Operand A |
| b_in | input | 1 | Operand B |
| c_in | input | 1 | Carry in |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion flag |
| sum | output | 1 | Sum, read from FF3 |
| cout | output | 1 | Carry out, read from FF1 |
| buf_q | output | NUM_BUF | Buffer contents for a neighbour; bit 0 = FF1, 1 = FF2, 2 = FF3 |

## Verification
All eight operand combinations are applied directly. Because the three rows with exactly one set bit produce a sum without a carry, a wrong inversion polarity in any single step shows up in FF2 or FF3, even when the carry is correct. Seeded random sequences then vary the operands and sometimes flip the inputs in mid-sequence, which separates latched operands from live ones. Some runs also issue a second start while busy, which exposes a sequencer that restarts or stretches. Idle gaps, a reset with the clear input low, and a separate clear pulse show whether the buffers retain their values or get wiped by the wrong signal.

// File: rtl/maj_adder_pkg.sv
package maj_adder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STEP1 = 3'd1,
        ST_STEP2 = 3'd2,
        ST_STEP3 = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_t;

    typedef enum logic [2:0] {
        SRC_A  = 3'd0,
        SRC_B  = 3'd1,
        SRC_C  = 3'd2,
        SRC_F1 = 3'd3,
        SRC_F2 = 3'd4,
        SRC_F3 = 3'd5
    } src_t;

    typedef struct packed {
        src_t       s0;
        src_t       s1;
        src_t       s2;
        logic [2:0] inv;
    } opsel_t;

    localparam int IDX_CARRY = 0;
    localparam int IDX_AUX   = 1;
    localparam int IDX_SUM   = 2;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/maj_gate.sv
module maj_gate (
    input  logic [2:0] opnd,
    input  logic [2:0] inv,
    output logic       y
);
    logic [2:0] eff;

    always_comb begin
        eff = opnd ^ inv;
        y   = (eff[0] & eff[1]) | (eff[0] & eff[2]) | (eff[1] & eff[2]);
    end
endmodule

// File: rtl/maj_buffer_bank.sv
module maj_buffer_bank #(
    parameter int NUM_BUF = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [NUM_BUF-1:0] wr_en,
    input  logic               wr_bit,
    output logic [NUM_BUF-1:0] q
);
    logic [NUM_BUF-1:0] buf_d, buf_q;

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_cell
        always_comb begin
            if (clr)
                buf_d[i] = 1'b0;
            else if (wr_en[i])
                buf_d[i] = wr_bit;
            else
                buf_d[i] = buf_q[i];
        end
    end

    always_ff @(posedge clk) begin
        buf_q <= buf_d;
    end

    assign q = buf_q;

    // R8: without a copy or clear, contents are retained
    a_r8_retain: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr_en == '0) |=> $stable(q));
    // R9: clear empties the whole bank
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));
    // R4: at most one buffer is written per step
    a_r4_single_copy: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));
endmodule

// File: rtl/maj_seq_ctrl.sv
module maj_seq_ctrl
    import maj_adder_pkg::*;
#(
    parameter int NUM_BUF = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               cap_en,
    output opsel_t             opsel,
    output logic [NUM_BUF-1:0] wr_en,
    output logic               busy,
    output logic               done
);
    typedef struct packed {
        seq_state_t st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d  = ctl_q;
        cap_en = 1'b0;
        wr_en  = '0;
        opsel  = '{s0: SRC_A, s1: SRC_B, s2: SRC_C, inv: 3'b000};
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    cap_en   = 1'b1;
                    ctl_d.st = ST_STEP1;
                end
            end
            ST_STEP1: begin
                wr_en[IDX_CARRY] = 1'b1;
                ctl_d.st         = ST_STEP2;
            end
            ST_STEP2: begin
                opsel.inv      = 3'b100;
                wr_en[IDX_AUX] = 1'b1;
                ctl_d.st       = ST_STEP3;
            end
            ST_STEP3: begin
                opsel          = '{s0: SRC_F1, s1: SRC_F2, s2: SRC_C, inv: 3'b001};
                wr_en[IDX_SUM] = 1'b1;
                ctl_d.st       = ST_DONE;
            end
            ST_DONE:  ctl_d.st = ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase
        if (rst) ctl_d.st = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign busy = (ctl_q.st != ST_IDLE);
    assign done = (ctl_q.st == ST_DONE);

    // R2: a start in idle launches step 1
    a_r2_launch: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (ctl_q.st == ST_STEP1));
    // R2: a busy sequencer never re-enters step 1
    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy |=> (ctl_q.st != ST_STEP1));
    // R3: done lasts a single cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R3: step 3 always hands over to done
    a_r3_step3_done: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_STEP3) |=> done);
endmodule

// File: rtl/maj_full_adder.sv
module maj_full_adder
    import maj_adder_pkg::*;
#(
    parameter int NUM_BUF = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               start,
    input  logic               a_in,
    input  logic               b_in,
    input  logic               c_in,
    output logic               busy,
    output logic               done,
    output logic               sum,
    output logic               cout,
    output logic [NUM_BUF-1:0] buf_q
);
    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } opnd_t;

    opnd_t              op_d, op_q;
    logic               cap_en;
    opsel_t             opsel;
    logic [NUM_BUF-1:0] wr_en;
    logic [2:0]         gate_in;
    logic               gate_y;

    maj_seq_ctrl #(.NUM_BUF(NUM_BUF)) u_seq (
        .clk(clk), .rst(rst), .start(start), .cap_en(cap_en),
        .opsel(opsel), .wr_en(wr_en), .busy(busy), .done(done)
    );

    function automatic logic pick(input src_t s, input opnd_t o,
                                  input logic [NUM_BUF-1:0] b);
        unique case (s)
            SRC_A:   return o.a;
            SRC_B:   return o.b;
            SRC_C:   return o.c;
            SRC_F1:  return b[IDX_CARRY];
            SRC_F2:  return b[IDX_AUX];
            SRC_F3:  return b[IDX_SUM];
            default: return 1'b0;
        endcase
    endfunction

    always_comb begin
        op_d = op_q;
        if (cap_en) op_d = '{a: a_in, b: b_in, c: c_in};
        if (rst)    op_d = '0;
        gate_in[0] = pick(opsel.s0, op_q, buf_q);
        gate_in[1] = pick(opsel.s1, op_q, buf_q);
        gate_in[2] = pick(opsel.s2, op_q, buf_q);
    end

    always_ff @(posedge clk) begin
        op_q <= op_d;
    end

    maj_gate u_gate (.opnd(gate_in), .inv(opsel.inv), .y(gate_y));

    maj_buffer_bank #(.NUM_BUF(NUM_BUF)) u_bank (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en),
        .wr_bit(gate_y), .q(buf_q)
    );

    assign cout = buf_q[IDX_CARRY];
    assign sum  = buf_q[IDX_SUM];

    // R4: carry buffer matches the majority of the latched operands
    a_r4_carry: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(clr)) |-> (cout == maj3(op_q.a, op_q.b, op_q.c)));
    // R6: sum buffer matches the parity of the latched operands
    a_r6_sum: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(clr)) |-> (sum == (op_q.a ^ op_q.b ^ op_q.c)));
    // R7: latched operands stay fixed while busy
    a_r7_hold_ops: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(op_q));
endmodule

// File: tb/sim_maj_full_adder.sv
module sim_maj_full_adder;
    logic       clk = 1'b0;
    logic       rst, clr, start, a_in, b_in, c_in;
    logic       busy, done, sum, cout;
    logic [2:0] buf_q;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    maj_full_adder #(.NUM_BUF(3)) u0 (
        .clk(clk), .rst(rst), .clr(clr), .start(start),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .busy(busy), .done(done), .sum(sum), .cout(cout), .buf_q(buf_q)
    );

    function automatic logic mj(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

    function automatic logic [2:0] exp_buf(input logic a, input logic b, input logic c);
        logic f1, f2;
        f1 = mj(a, b, c);
        f2 = mj(a, b, ~c);
        return {mj(~f1, f2, c), f2, f1};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full sequence; optional input scramble and extra start while busy
    task automatic run(input logic a, input logic b, input logic c,
                       input bit scramble, input bit restart);
        logic [2:0] e;
        e = exp_buf(a, b, c);
        a_in = a; b_in = b; c_in = c; start = 1'b1;
        tick();
        start = 1'b0;
        if (scramble) begin a_in = ~a; b_in = ~b; c_in = ~c; end
        chk(busy && !done, "R3 busy after start", {busy, done}, 2);
        if (restart) start = 1'b1;
        tick();
        start = 1'b0;
        chk(!done, "R3 no early done", done, 0);
        tick();
        if (restart) start = 1'b1;
        chk(!done, "R3 no early done step3", done, 0);
        tick();
        start = 1'b0;
        chk(done && busy, "R3 done at third edge", {busy, done}, 3);
        chk(buf_q[0] == e[0], "R4 FF1 carry", buf_q[0], e[0]);
        chk(buf_q[1] == e[1], "R5 FF2 aux", buf_q[1], e[1]);
        chk(buf_q[2] == e[2], "R6 FF3 sum", buf_q[2], e[2]);
        chk({cout, sum} == 2'(a + b + c), "R6 R7 cout,sum vs A+B+Cin",
            {cout, sum}, a + b + c);
        tick();
        chk(!done && !busy, "R2 R3 back to idle", {busy, done}, 0);
    endtask

    initial begin
        logic [2:0] held;
        rst = 1'b1; clr = 1'b1; start = 1'b0;
        a_in = 1'b0; b_in = 1'b0; c_in = 1'b0;
        tick(); tick();
        chk(!busy && !done, "R1 reset idle", {busy, done}, 0);
        chk(buf_q == 3'b000, "R9 clear at startup", buf_q, 0);
        rst = 1'b0; clr = 1'b0;
        tick();

        for (int v = 0; v < 8; v++)
            run(v[2], v[1], v[0], 1'b0, 1'b0);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 40; i++) begin
            logic [2:0] r;
            r = 3'($urandom);
            run(r[2], r[1], r[0], 1'($urandom), 1'($urandom));
            for (int g = 0; g < int'($urandom % 3); g++) tick();
        end

        // R7 directed: all inputs flip right after start
        run(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);

        // R8: retention across idle and reset
        run(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        held = buf_q;
        chk(held == exp_buf(1'b1, 1'b1, 1'b0), "R8 value before idle", held, exp_buf(1'b1, 1'b1, 1'b0));
        a_in = 1'b0; b_in = 1'b0; c_in = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        chk(buf_q == held, "R8 hold across idle", buf_q, held);
        rst = 1'b1;
        start = 1'b1;
        tick(); tick();
        start = 1'b0;
        rst = 1'b0;
        chk(buf_q == held, "R8 hold across reset", buf_q, held);
        chk(!busy && !done, "R1 reset wins over start", {busy, done}, 0);
        tick();
        chk(!busy, "R1 still idle after reset", busy, 0);

        // R9: clear pulse
        clr = 1'b1;
        tick();
        clr = 1'b0;
        chk(buf_q == 3'b000, "R9 clear empties buffers", buf_q, 0);
        tick();
        chk(buf_q == 3'b000 && !busy, "R9 clear leaves sequencer idle", buf_q, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule